// File: doc/BRIEF.md
# Self-Timed Byte Program and Erase Sequencer

This block runs one flash write operation at a time on behalf of a command controller. The controller is expected to have already decoded the host's command. An operation is either a single-byte program or an erase of one of three regions. The block drives the array's write and erase enables and holds a ready/busy flag low for the whole operation. A watchdog raises a failure flag when an operation runs past its time limit. A small byte-wide array is modelled inside the block so that program, internal verify and erase can be observed. A second read port lets the controller, or a bench, read the stored bytes back.

A program operation never sets bits: the stored byte becomes the old byte ANDed with the requested byte. After each program pulse, the stored byte is read back and compared with the requested byte. When they differ, the block pulses again. This repeats until they match or until reset. As a result, a location that was not erased first, or a bit that is stuck, leaves the block busy, and the watchdog then flags the failure. The watchdog limit is counted from the accepted start. Each rising edge of the write strobe clears the timeout flag and restarts the count. All durations are parameters in clock cycles.

Top module: `pe_sequencer`

## Requirements
- R1: After reset, `ready` is 1, `timeout` is 0, and `arr_we` and `arr_ee` are 0.
- R2: A `start` sampled while `ready` is 1 is accepted. From the next cycle `ready` is 0 and `timeout` is 0.
- R3: `op` = 2'b00 is a byte program. The stored byte becomes old AND `wdata`. `arr_we` is 0 in the first busy cycle and 1 in the second. When the read-back matches `wdata`, `ready` returns to 1 exactly PROG_PULSE+3 cycles after the accepting edge.
- R4: When the read-back differs from `wdata`, the block pulses `arr_we` again and `ready` stays 0. Programming a 1 over a stored 0 therefore never completes, and the stored byte holds the ANDed value.
- R5: If `ready` is still 0 exactly WDOG_PROG cycles after a program start is accepted, `timeout` goes to 1 and `ready` stays 0.
- R6: A `wr_rise` pulse clears `timeout` in the next cycle and restarts the limit from its own edge. When it lands on the same edge as an expiry, the clear wins.
- R7: `op` selects the erase region: 2'b01 the whole array, 2'b10 addresses below HI_BASE, 2'b11 addresses from HI_BASE up. Every byte in the region becomes all ones and bytes outside it are unchanged. `arr_ee` is 1 while busy, and `ready` returns to 1 exactly (region size) cycles after the accepting edge.
- R8: A `start` sampled while `ready` is 0 is ignored. The running operation, its timing and the array are unaffected.
- R9: Erase operations use the WDOG_ERASE limit instead of WDOG_PROG.
- R10: `arr_we` and `arr_ee` are never 1 together, and either is 1 only while `ready` is 0.
- R11: `rd_data` shows the byte stored at `rd_addr` one cycle after `rd_addr` is applied. A bit configured as stuck reads as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin an operation |
| op | input | 2 | Operation: 00 program, 01 erase all, 10 erase low region, 11 erase high region |
| addr | input | ADDR_W | Byte address for program |
| wdata | input | DATA_W | Byte to program |
| wr_rise | input | 1 | One-cycle pulse on a write-strobe rising edge |
| rd_addr | input | ADDR_W | Read-back address |
| rd_data | output | DATA_W | Read-back byte, one cycle latency |
| ready | output | 1 | 1 ready, 0 operation in progress |
| timeout | output | 1 | Watchdog expired during the operation |
| arr_we | output | 1 | Array program enable |
| arr_ee | output | 1 | Array erase enable |

## Verification
Two events can fall on the same cycle: a watchdog expiry and a `wr_rise` pulse. The bench forces a program that can never verify. It clears the flag once with `wr_rise`, and then places a second `wr_rise` so that it is sampled on exactly the edge where the count would expire. In that case `timeout` must stay 0 on that edge and must rise a full limit later, counted from the pulse. The bench also issues a chip-erase `start` in the middle of a busy program. It then checks that the program completes on its normal cycle and that no byte was erased.

// File: rtl/pe_pkg.sv
package pe_pkg;
  typedef enum logic [1:0] {
    OP_PROG      = 2'b00,
    OP_ERASE_ALL = 2'b01,
    OP_ERASE_LO  = 2'b10,
    OP_ERASE_HI  = 2'b11
  } pe_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_PULSE,
    ST_SETTLE,
    ST_CHECK,
    ST_ERASE
  } pe_state_e;
endpackage

// File: rtl/pe_array.sv
module pe_array #(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter bit STUCK_EN   = 1'b0,
  parameter int STUCK_ADDR = 0,
  parameter int STUCK_BIT  = 0
) (
  input  logic              clk,
  input  logic              we,
  input  logic              ee,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] raw_q, raw_rd;
  logic [ADDR_W-1:0] q_addr_r, rd_addr_r;

  always_ff @(posedge clk) begin
    if (ee) begin
      mem[addr] <= '1;
    end else if (we) begin
      mem[addr] <= wdata;
    end
    raw_q     <= mem[addr];
    raw_rd    <= mem[rd_addr];
    q_addr_r  <= addr;
    rd_addr_r <= rd_addr;
  end

  generate
    if (STUCK_EN) begin : g_stuck
      localparam logic [ADDR_W-1:0] SA = ADDR_W'(STUCK_ADDR);
      localparam logic [DATA_W-1:0] SM = DATA_W'(1) << STUCK_BIT;
      assign q       = (q_addr_r  == SA) ? (raw_q  | SM) : raw_q;
      assign rd_data = (rd_addr_r == SA) ? (raw_rd | SM) : raw_rd;
    end else begin : g_clean
      assign q       = raw_q;
      assign rd_data = raw_rd;
    end
  endgenerate
endmodule

// File: rtl/pe_watchdog.sv
module pe_watchdog #(
  parameter int WDOG_PROG  = 40,
  parameter int WDOG_ERASE = 600
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic erase_sel,
  input  logic busy,
  input  logic wr_rise,
  output logic timeout
);
  localparam int WMAX = (WDOG_PROG > WDOG_ERASE) ? WDOG_PROG : WDOG_ERASE;
  localparam int CW   = $clog2(WMAX + 1);

  logic [CW-1:0] cnt, lim;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      lim     <= CW'(WDOG_PROG);
      timeout <= 1'b0;
    end else if (arm) begin
      cnt     <= '0;
      lim     <= erase_sel ? CW'(WDOG_ERASE) : CW'(WDOG_PROG);
      timeout <= 1'b0;
    end else if (wr_rise) begin
      cnt     <= '0;
      timeout <= 1'b0;
    end else if (busy && !timeout) begin
      if (cnt == lim - CW'(1)) timeout <= 1'b1;
      else                     cnt     <= cnt + CW'(1);
    end
  end

  assert_wr_clears_R6: assert property (@(posedge clk) disable iff (rst)
    wr_rise |=> !timeout);
  assert_expiry_while_busy_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(timeout) |-> $past(busy));
endmodule

// File: rtl/pe_ctrl.sv
module pe_ctrl
  import pe_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int PROG_PULSE = 4,
  parameter int HI_BASE    = 240
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] arr_q,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_wdata,
  output logic              arr_we,
  output logic              arr_ee,
  output logic              ready
);
  localparam int PW = $clog2(PROG_PULSE + 1);
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(HI_BASE);

  pe_state_e         state;
  logic [PW-1:0]     pcnt;
  logic [ADDR_W-1:0] addr_q, walk, last;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      pcnt   <= '0;
      addr_q <= '0;
      data_q <= '0;
      walk   <= '0;
      last   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          addr_q <= addr;
          data_q <= wdata;
          case (pe_op_e'(op))
            OP_PROG:      state <= ST_FETCH;
            OP_ERASE_ALL: begin walk <= '0;   last <= '1;            state <= ST_ERASE; end
            OP_ERASE_LO:  begin walk <= '0;   last <= BASE - 1'b1;   state <= ST_ERASE; end
            default:      begin walk <= BASE; last <= '1;            state <= ST_ERASE; end
          endcase
        end
        ST_FETCH: begin
          pcnt  <= '0;
          state <= ST_PULSE;
        end
        ST_PULSE: begin
          if (pcnt == PW'(PROG_PULSE - 1)) state <= ST_SETTLE;
          else                             pcnt  <= pcnt + PW'(1);
        end
        ST_SETTLE: state <= ST_CHECK;
        ST_CHECK: begin
          if (arr_q == data_q) state <= ST_IDLE;
          else begin
            pcnt  <= '0;
            state <= ST_PULSE;
          end
        end
        ST_ERASE: begin
          if (walk == last) state <= ST_IDLE;
          else              walk  <= walk + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign ready     = (state == ST_IDLE);
  assign arr_we    = (state == ST_PULSE);
  assign arr_ee    = (state == ST_ERASE);
  assign arr_addr  = (state == ST_ERASE) ? walk : addr_q;
  assign arr_wdata = arr_q & data_q;

  assert_enables_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
    !(arr_we && arr_ee));
  assert_enables_only_busy_R10: assert property (@(posedge clk) disable iff (rst)
    (arr_we || arr_ee) |-> !ready);
  assert_busy_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (start && !ready) |=> ($stable(addr_q) && $stable(data_q)));
  assert_mismatch_retries_R4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CHECK && arr_q != data_q) |=> arr_we);
endmodule

// File: rtl/pe_sequencer.sv
module pe_sequencer
  import pe_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int PROG_PULSE = 4,
  parameter int WDOG_PROG  = 40,
  parameter int WDOG_ERASE = 600,
  parameter int HI_BASE    = 240,
  parameter bit STUCK_EN   = 1'b0,
  parameter int STUCK_ADDR = 0,
  parameter int STUCK_BIT  = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr_rise,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              ready,
  output logic              timeout,
  output logic              arr_we,
  output logic              arr_ee
);
  logic [ADDR_W-1:0] a_addr;
  logic [DATA_W-1:0] a_wdata, a_q;

  pe_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROG_PULSE(PROG_PULSE), .HI_BASE(HI_BASE)
  ) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .op(op), .addr(addr), .wdata(wdata),
    .arr_q(a_q), .arr_addr(a_addr), .arr_wdata(a_wdata),
    .arr_we(arr_we), .arr_ee(arr_ee), .ready(ready)
  );

  pe_watchdog #(.WDOG_PROG(WDOG_PROG), .WDOG_ERASE(WDOG_ERASE)) u_wdog (
    .clk(clk), .rst(rst), .arm(start && ready), .erase_sel(op != 2'b00),
    .busy(!ready), .wr_rise(wr_rise), .timeout(timeout)
  );

  pe_array #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STUCK_EN(STUCK_EN),
    .STUCK_ADDR(STUCK_ADDR), .STUCK_BIT(STUCK_BIT)
  ) u_array (
    .clk(clk), .we(arr_we), .ee(arr_ee), .addr(a_addr), .wdata(a_wdata),
    .q(a_q), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  assert_accept_drops_ready_R2: assert property (@(posedge clk) disable iff (rst)
    (start && ready) |=> (!ready && !timeout));
endmodule

// File: tb/pe_sequencer_bench.sv
module pe_sequencer_bench;
  localparam int P  = 4;
  localparam int WP = 40;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, wr_rise = 1'b0;
  logic [1:0] op = 2'b00;
  logic [7:0] addr = '0, wdata = '0, rd_addr = '0, rd_data;
  logic ready, timeout, arr_we, arr_ee;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  pe_sequencer #(.PROG_PULSE(P), .WDOG_PROG(WP), .WDOG_ERASE(600), .HI_BASE(240),
                 .STUCK_EN(1'b1), .STUCK_ADDR(8'h5A), .STUCK_BIT(3)) u_pe_sequencer (
    .clk(clk), .rst(rst), .start(start), .op(op), .addr(addr), .wdata(wdata),
    .wr_rise(wr_rise), .rd_addr(rd_addr), .rd_data(rd_data), .ready(ready),
    .timeout(timeout), .arr_we(arr_we), .arr_ee(arr_ee));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic kick(logic [1:0] o, logic [7:0] a, logic [7:0] d);
    @(negedge clk); start = 1'b1; op = o; addr = a; wdata = d;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done(int n, string req);
    repeat (n - 1) @(negedge clk);
    check(req, ready, 1'b0);
    @(negedge clk);
    check(req, ready, 1'b1);
  endtask

  task automatic rd_chk(logic [7:0] a, logic [7:0] exp, string req);
    @(negedge clk); rd_addr = a;
    @(negedge clk); check(req, rd_data, exp);
  endtask

  task automatic do_reset();
    rst = 1'b1; start = 1'b0; wr_rise = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 ready", ready, 1'b1);
    check("R1 timeout", timeout, 1'b0);
    check("R1 enables", {arr_we, arr_ee}, 2'b00);
  endtask

  task automatic t_chip_erase();
    kick(2'b01, 8'h00, 8'h00);
    check("R2 ready low", ready, 1'b0);
    check("R7 ee", arr_ee, 1'b1);
    wait_done(256, "R7 chip erase time");
    check("R9 no prog-limit timeout on erase", timeout, 1'b0);
    rd_chk(8'h00, 8'hFF, "R7 erased 00");
    rd_chk(8'hFF, 8'hFF, "R7 erased FF");
  endtask

  task automatic t_program();
    kick(2'b00, 8'h10, 8'hA5);
    check("R3 we first cycle", arr_we, 1'b0);
    @(negedge clk);
    check("R3 we second cycle", arr_we, 1'b1);
    wait_done(P + 2, "R3 program time");
    rd_chk(8'h10, 8'hA5, "R3 stored");
    rd_chk(8'h11, 8'hFF, "R11 neighbour untouched");
  endtask

  task automatic t_ignore_busy();
    kick(2'b00, 8'h20, 8'h3C);
    @(negedge clk); start = 1'b1; op = 2'b01;
    @(negedge clk); start = 1'b0;
    wait_done(P + 1, "R8 timing kept");
    rd_chk(8'h10, 8'hA5, "R8 no erase");
    rd_chk(8'h20, 8'h3C, "R8 program kept");
  endtask

  task automatic t_regions();
    kick(2'b00, 8'hEF, 8'h77); wait_done(P + 3, "R3 prog EF");
    kick(2'b00, 8'hF0, 8'h11); wait_done(P + 3, "R3 prog F0");
    kick(2'b11, 8'h00, 8'h00); wait_done(16, "R7 high erase time");
    rd_chk(8'hF0, 8'hFF, "R7 high erased");
    rd_chk(8'hEF, 8'h77, "R7 low kept");
    kick(2'b00, 8'hF0, 8'h12); wait_done(P + 3, "R3 prog F0 again");
    kick(2'b10, 8'h00, 8'h00); wait_done(240, "R7 low erase time");
    rd_chk(8'hEF, 8'hFF, "R7 low erased");
    rd_chk(8'hF0, 8'h12, "R7 high kept");
  endtask

  task automatic t_timeout_race();
    kick(2'b00, 8'h64, 8'hF0); wait_done(P + 3, "R3 prog 64");
    kick(2'b00, 8'h64, 8'h0F);
    repeat (WP - 1) @(negedge clk);
    check("R5 before limit", timeout, 1'b0);
    @(negedge clk);
    check("R5 at limit", timeout, 1'b1);
    check("R5 still busy", ready, 1'b0);
    @(negedge clk); wr_rise = 1'b1;
    @(negedge clk); wr_rise = 1'b0;
    check("R6 cleared", timeout, 1'b0);
    repeat (WP - 1) @(negedge clk);
    check("R6 restart before", timeout, 1'b0);
    wr_rise = 1'b1;
    @(negedge clk); wr_rise = 1'b0;
    check("R6 clear wins collision", timeout, 1'b0);
    repeat (WP - 1) @(negedge clk);
    check("R6 after collision before", timeout, 1'b0);
    @(negedge clk);
    check("R6 after collision expiry", timeout, 1'b1);
    do_reset();
    rd_chk(8'h64, 8'h00, "R4 bits only cleared");
  endtask

  task automatic t_stuck();
    int seen;
    seen = 0;
    kick(2'b00, 8'h5A, 8'h00);
    repeat (WP + 20) begin
      @(negedge clk);
      if (timeout && arr_we) seen++;
    end
    check("R4 retries after timeout", (seen >= 2) ? 1 : 0, 1);
    check("R4 still busy", ready, 1'b0);
    do_reset();
    rd_chk(8'h5A, 8'h08, "R11 stuck bit reads one");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    t_chip_erase();
    t_program();
    t_ignore_busy();
    t_regions();
    t_timeout_race();
    t_stuck();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule